// File: doc/BRIEF.md
# Dual-Line Digital Inspection Multiplexer

This block lets a test engineer watch internal logic signals of a multi-channel detector front end on two digital inspection pins. Six identical shield channels each expose 24 single-bit logic signals. A single 16-bit control word picks what each of the two inspection lines shows. Each line first chooses a shield and then one signal within that shield. Some encodings leave the line disconnected, and a disconnected line is held low.

The control word sits behind a plain write-enable port and can always be read back. Both inspection outputs are registered, so they are clean, glitch-free copies of the chosen signal and lag the probe inputs by one clock. Reset is asserted asynchronously and released synchronously. After reset the control word is zero, so both lines start disconnected.

Top module: `insp_digital_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, the read-back word is 0 and both inspection outputs are low.
- R2: A rising clock edge with `wr_en` high loads `wr_data` into the control word, and `rd_data` shows the new value after that edge. While `wr_en` is low the control word keeps its value, whatever is on `wr_data`.
- R3: Control bits 7:0 configure line 0 (`line_out[0]`) and bits 15:8 configure line 1 (`line_out[1]`). The two lines select independently of each other.
- R4: Within each line's byte, bits 2:0 are the shield code and bits 7:3 are the signal code. Shield codes 1 to 6 select shields 1 to 6.
- R5: Shield code 0 disconnects the line, so its output is low whatever the probe inputs are.
- R6: Shield code 7 is unused and drives the output low.
- R7: Signal codes 0 to 23 select probe bit `(shield-1)*24 + code` of `probe_in`. Within a shield, codes 0 to 9 are the ten element discriminators (a to j). Codes 10 to 13 are the timing signals: TAC start, fast trigger, peak gate and trigger window. Codes 14 to 23 are the trigger and readout control signals, in their fixed order.
- R8: Signal codes 24 to 31 are unused and drive the output low.
- R9: Each output is registered. After a clock edge it equals the probe bit chosen by the control word as it stood before that edge, sampled at that edge. A write therefore changes what a line shows one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word read-back |
| probe_in | input | 144 | Probe signals, shield-major: shield s, signal p at bit (s-1)*24+p |
| line_out | output | 2 | Registered inspection outputs, line 0 in bit 0 |

## Verification
The bench builds the block with its default parameters: six shields, 24 signals per shield, a 3-bit shield field and a 5-bit signal field. With these values every shield code, including the unused code 7, and every signal code, including the unused codes 24 to 31, can be written. A full sweep of all 144 valid shield and signal pairs is run on both lines against random probe patterns. Each write step is checked on the edge where the new selection must not yet be visible.

// File: rtl/insp_mux_pkg.sv
package insp_mux_pkg;
  localparam int unsigned SHIELDS_DEF  = 6;
  localparam int unsigned SIGNALS_DEF  = 24;
  localparam int unsigned SH_FIELD_DEF = 3;
  localparam int unsigned SG_FIELD_DEF = 5;
  localparam int unsigned LINES_DEF    = 2;
endpackage

// File: rtl/insp_rst_sync.sv
module insp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/insp_ctrl_reg.sv
module insp_ctrl_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] ctrl_q
);
  logic [WIDTH-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R2: a write is visible on the next cycle
  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == $past(wr_data)));

  // R2: no write, no change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/insp_line_sel.sv
module insp_line_sel #(
  parameter int unsigned SHIELDS  = 6,
  parameter int unsigned SIGNALS  = 24,
  parameter int unsigned SH_FIELD = 3,
  parameter int unsigned SG_FIELD = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SH_FIELD+SG_FIELD-1:0] sel_byte,
  input  logic [SHIELDS*SIGNALS-1:0]   probe_in,
  output logic                         line_q
);
  localparam int unsigned BYTE_W = SH_FIELD + SG_FIELD;

  logic [SH_FIELD-1:0] sh_code;
  logic [SG_FIELD-1:0] sg_code;
  logic [SIGNALS-1:0]  slice;
  logic                shield_hit;
  logic                sig_bit;
  logic                line_d;

  assign sh_code = sel_byte[SH_FIELD-1:0];
  assign sg_code = sel_byte[BYTE_W-1:SH_FIELD];

  // first level: pick one shield's signal bundle
  always_comb begin
    slice      = '0;
    shield_hit = 1'b0;
    for (int s = 0; s < int'(SHIELDS); s++) begin
      if (sh_code == SH_FIELD'(s + 1)) begin
        slice      = probe_in[s*SIGNALS +: SIGNALS];
        shield_hit = 1'b1;
      end
    end
  end

  // second level: pick one signal within the bundle
  always_comb begin
    sig_bit = 1'b0;
    for (int p = 0; p < int'(SIGNALS); p++) begin
      if (sg_code == SG_FIELD'(p)) sig_bit = slice[p];
    end
  end

  always_comb line_d = shield_hit & sig_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  // R5: disconnected line stays low
  p_disc_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_code == '0) |=> !line_q);

  // R6: codes above the shield count stay low
  p_bad_shield_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sh_code) > int'(SHIELDS)) |=> !line_q);

  // R8: signal codes past the bundle stay low
  p_bad_signal_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sg_code) >= int'(SIGNALS)) |=> !line_q);

  // R7 / R9: valid selection shows the probe bit of the previous edge
  p_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sh_code != '0) && (int'(sh_code) <= int'(SHIELDS)) && (int'(sg_code) < int'(SIGNALS)))
    |=> (line_q == $past(probe_in[(int'(sh_code) - 1) * int'(SIGNALS) + int'(sg_code)])));
endmodule

// File: rtl/insp_digital_mux.sv
module insp_digital_mux
  import insp_mux_pkg::*;
#(
  parameter int unsigned SHIELDS  = SHIELDS_DEF,
  parameter int unsigned SIGNALS  = SIGNALS_DEF,
  parameter int unsigned SH_FIELD = SH_FIELD_DEF,
  parameter int unsigned SG_FIELD = SG_FIELD_DEF,
  parameter int unsigned LINES    = LINES_DEF,
  localparam int unsigned BYTE_W  = SH_FIELD + SG_FIELD,
  localparam int unsigned CTRL_W  = BYTE_W * LINES,
  localparam int unsigned PROBE_W = SHIELDS * SIGNALS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  rd_data,
  input  logic [PROBE_W-1:0] probe_in,
  output logic [LINES-1:0]   line_out
);
  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_q;

  insp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  insp_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  assign rd_data = ctrl_q;

  for (genvar l = 0; l < int'(LINES); l++) begin : g_line
    insp_line_sel #(
      .SHIELDS  (SHIELDS),
      .SIGNALS  (SIGNALS),
      .SH_FIELD (SH_FIELD),
      .SG_FIELD (SG_FIELD)
    ) u_sel (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .sel_byte (ctrl_q[l*BYTE_W +: BYTE_W]),
      .probe_in (probe_in),
      .line_q   (line_out[l])
    );
  end

  // R1: reset state at the ports
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (rd_data == '0 && line_out == '0));
endmodule

// File: tb/insp_digital_mux_tb.sv
module insp_digital_mux_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [15:0]  wr_data;
  logic [15:0]  rd_data;
  logic [143:0] probe_in;
  logic [1:0]   line_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] model_ctrl = 16'h0;

  always #2.5 clk = ~clk;

  insp_digital_mux u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .probe_in (probe_in),
    .line_out (line_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 50000", cycles);
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  function automatic logic ref_line(input logic [7:0] b, input logic [143:0] pr);
    int sh = int'(b[2:0]);
    int sg = int'(b[7:3]);
    if (sh >= 1 && sh <= 6 && sg < 24) return pr[(sh - 1) * 24 + sg];
    return 1'b0;
  endfunction

  function automatic logic [143:0] rnd_probe();
    logic [143:0] v = '0;
    for (int i = 0; i < 5; i++) v = {v[111:0], 32'($urandom)};
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; compare just after the following negedge
  task automatic step(input string tag);
    logic e0, e1;
    @(posedge clk);
    e0 = ref_line(model_ctrl[7:0], probe_in);
    e1 = ref_line(model_ctrl[15:8], probe_in);
    if (wr_en && rst_n) model_ctrl = wr_data;
    @(negedge clk);
    check({tag, " rd"}, 32'(rd_data), 32'(model_ctrl));
    check({tag, " line0"}, 32'(line_out[0]), 32'(e0));
    check({tag, " line1"}, 32'(line_out[1]), 32'(e1));
  endtask

  task automatic wr(input logic [15:0] v, input string tag);
    wr_en = 1'b1; wr_data = v; probe_in = rnd_probe();
    step(tag);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] sel(input int sh, input int sg);
    return {5'(sg), 3'(sh)};
  endfunction

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 16'h0; probe_in = '1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1 in reset");
    check("R1 reset rd", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin probe_in = rnd_probe(); step("R1 after release"); end

    // R3 R4 R7 R9: independent selections, write edge shows old selection
    wr({sel(6, 23), sel(2, 5)}, "R9 write edge");
    for (int i = 0; i < 8; i++) begin probe_in = rnd_probe(); step("R3 R4 R7 routing"); end
    probe_in = '0; probe_in[1*24 + 5] = 1'b1;
    step("R3 line0 only");
    probe_in = '0; probe_in[5*24 + 23] = 1'b1;
    step("R3 line1 only");

    // R2: idle write data ignored
    wr_data = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin probe_in = rnd_probe(); step("R2 hold"); end
    check("R2 readback", 32'(rd_data), 32'({sel(6, 23), sel(2, 5)}));

    // R5: disconnected line with all probes high
    wr({sel(0, 3), sel(0, 12)}, "R5 write");
    probe_in = '1; step("R5 disconnected");
    step("R5 disconnected");

    // R6: shield code 7
    wr({sel(7, 0), sel(7, 9)}, "R6 write");
    probe_in = '1; step("R6 unused shield");
    step("R6 unused shield");

    // R8: signal codes 24..31
    for (int g = 24; g < 32; g++) begin
      wr({sel(1 + (g % 6), g), sel(3, g)}, "R8 write");
      probe_in = '1; step("R8 unused signal");
    end

    // R7 R4 R9: full sweep on both lines
    for (int s = 1; s <= 6; s++) begin
      for (int g = 0; g < 24; g++) begin
        wr({sel(7 - s, 23 - g), sel(s, g)}, "R9 sweep write");
        probe_in = rnd_probe(); step("R7 sweep");
        probe_in = ~probe_in;   step("R7 sweep inverted");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule